// File: doc/BRIEF.md
# Gate-Signal Edge Timestamp Capture

This block watches a group of PWM gate inputs with a fast clock that ticks many times per simulation step. Within each step it finds the earliest change on any watched input and records three things about it: which input changed, the level it changed to, and how many fast cycles into the step it was seen. A one-cycle step strobe marks the step boundaries. At the boundary that closes a step, the record is placed on a set of output registers. Those registers stay unchanged through the whole following step, so a downstream state-compensation stage can read them at any point in that step.

The compensation stage therefore sees each change one full step after the step in which it happened. The intervening step runs as if the input had not changed, and the timestamp then corrects the state in the step after it. When oversampling is switched off, the inputs are compared only on strobe cycles. Every recorded change then carries timestamp zero, and any pulse that starts and ends between two strobes is never seen.

Top module: `gate_edge_stamp`

## Requirements
- R1: While reset is active, and after it is released until the first publication, ev_valid, ev_chan, ev_level and ev_stamp are all zero.
- R2: With oversampling on, an input change first sampled at the clock edge that is j cycles after the strobe edge is reported with ev_stamp = j+2. The two extra cycles are the two synchronizer stages. The strobe edge itself is index 0.
- R3: Only the first detected change in a step is recorded. Later changes in the same step, on the same input or on other inputs, have no effect on the published event.
- R4: The event of a step is published at the strobe that ends that step. The outputs change only at the clock edge where step_strobe is sampled high, and they hold their value until the next such edge.
- R5: A step in which no change is detected publishes ev_valid = 0, with ev_chan, ev_level and ev_stamp all zero.
- R6: When changes on several inputs are detected at the same clock edge, the input with the lowest index is reported in ev_chan.
- R7: ev_level is the new level of the reported input: 1 for a rising change, 0 for a falling change.
- R8: The sub-step index stops at SUBSTEPS-1. If a step lasts longer than SUBSTEPS cycles, a change detected late in it is stamped SUBSTEPS-1.
- R9: With oversample_en low, inputs are compared with their previous value only on strobe edges. A change found there is recorded with stamp 0 and published at the following strobe. A pulse that starts and ends between two strobes produces no event.
- R10: A change detected at the strobe edge itself belongs to the step that the strobe opens. It is recorded with stamp 0, and it blocks later changes in that step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sub-step sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_strobe | input | 1 | One-cycle pulse marking a simulation step boundary |
| oversample_en | input | 1 | High: sample every cycle; low: compare only at strobes |
| gate_in | input | NCH | Asynchronous gate-drive inputs |
| ev_valid | output | 1 | Published event present for the step |
| ev_chan | output | CHW | Index of the input that changed first |
| ev_level | output | 1 | New level of that input |
| ev_stamp | output | TSW | Sub-step index at which the change was detected |

## Verification
A wrong sub-step counter shows up in the stamp published one step later, so a timestamp that is off by one is exposed at the first strobe after the faulty step. A capture register that keeps updating after the first change reports a later input or a later stamp at that same publication. A prev-sample register that updates in the wrong mode either drops the change or shows a filtered pulse, and the error appears two strobes after the stimulus. Checking the outputs again at the last cycle of every step catches any update that happens away from a strobe within that step.

// File: rtl/gate_edge_stamp.sv
module gate_edge_stamp #(
  parameter int NCH = 6,
  parameter int SUBSTEPS = 80,
  localparam int TSW = (SUBSTEPS > 1) ? $clog2(SUBSTEPS) : 1,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_strobe,
  input  logic           oversample_en,
  input  logic [NCH-1:0] gate_in,
  output logic           ev_valid,
  output logic [CHW-1:0] ev_chan,
  output logic           ev_level,
  output logic [TSW-1:0] ev_stamp
);

  localparam logic [TSW-1:0] LAST  = TSW'(SUBSTEPS - 1);
  localparam logic [TSW-1:0] FIRST = (SUBSTEPS > 1) ? TSW'(1) : '0;

  logic [NCH-1:0] sync_a, sync_b, prev_lvl, edge_vec;
  logic [TSW-1:0] cnt, pos;
  logic           look, edge_any;
  logic [CHW-1:0] pick;

  logic           cap_hit, cap_lvl;
  logic [CHW-1:0] cap_ch;
  logic [TSW-1:0] cap_ts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a   <= '0;
      sync_b   <= '0;
      prev_lvl <= '0;
    end else begin
      sync_a <= gate_in;
      sync_b <= sync_a;
      if (look) prev_lvl <= sync_b;
    end
  end

  assign look     = oversample_en || step_strobe;
  assign edge_vec = look ? (sync_b ^ prev_lvl) : '0;
  assign edge_any = |edge_vec;
  assign pos      = step_strobe ? '0 : cnt;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (edge_vec[i]) pick = CHW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (step_strobe) cnt <= FIRST;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_hit <= 1'b0;
      cap_ch  <= '0;
      cap_lvl <= 1'b0;
      cap_ts  <= '0;
    end else if (step_strobe || (!cap_hit && edge_any)) begin
      cap_hit <= edge_any;
      cap_ch  <= edge_any ? pick : '0;
      cap_lvl <= edge_any ? sync_b[pick] : 1'b0;
      cap_ts  <= edge_any ? pos : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_chan  <= '0;
      ev_level <= 1'b0;
      ev_stamp <= '0;
    end else if (step_strobe) begin
      ev_valid <= cap_hit;
      ev_chan  <= cap_ch;
      ev_level <= cap_lvl;
      ev_stamp <= cap_ts;
    end
  end

  a_r4_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !step_strobe |=> $stable({ev_valid, ev_chan, ev_level, ev_stamp}));

  a_r5_idle_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |-> (ev_chan == '0 && !ev_level && ev_stamp == '0));

  a_r3_first_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hit && !step_strobe) |=> (cap_hit && $stable({cap_ch, cap_lvl, cap_ts})));

  a_r8_counter_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_strobe && cnt == LAST) |=> cnt == LAST);

  a_r9_no_capture_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!oversample_en && !step_strobe) |=> $stable({cap_hit, cap_ch, cap_lvl, cap_ts}));

  a_r10_strobe_edge_stamp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step_strobe && edge_any) |=> (cap_hit && cap_ts == '0));

endmodule

// File: tb/tb_gate_edge_stamp.sv
module tb_gate_edge_stamp;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int SUB = 16;
  localparam int CHW = 2;
  localparam int TSW = 4;

  logic clk = 1'b0, rst_n = 1'b0, step_strobe = 1'b0, oversample_en = 1'b1;
  logic [NCH-1:0] gate_in = '0;
  logic           ev_valid, ev_level;
  logic [CHW-1:0] ev_chan;
  logic [TSW-1:0] ev_stamp;

  gate_edge_stamp #(.NCH(NCH), .SUBSTEPS(SUB)) dut (
    .clk(clk), .rst_n(rst_n), .step_strobe(step_strobe), .oversample_en(oversample_en),
    .gate_in(gate_in), .ev_valid(ev_valid), .ev_chan(ev_chan), .ev_level(ev_level),
    .ev_stamp(ev_stamp));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {en, m1, j1, m2, j2, len, tag}
  localparam int VN = 12;
  localparam logic [36:0] VECS [VN] = '{
    {1'b1, 4'b0001, 8'd2,  4'b0000, 8'd0, 8'd12, 4'd2},
    {1'b1, 4'b0100, 8'd0,  4'b0010, 8'd5, 8'd12, 4'd3},
    {1'b1, 4'b0000, 8'd0,  4'b0000, 8'd0, 8'd12, 4'd5},
    {1'b1, 4'b1010, 8'd4,  4'b0000, 8'd0, 8'd12, 4'd6},
    {1'b1, 4'b0001, 8'd1,  4'b0000, 8'd0, 8'd12, 4'd7},
    {1'b1, 4'b1000, 8'd18, 4'b0000, 8'd0, 8'd24, 4'd8},
    {1'b1, 4'b0100, 8'd10, 4'b0000, 8'd0, 8'd12, 4'd10},
    {1'b1, 4'b0001, 8'd3,  4'b0000, 8'd0, 8'd12, 4'd10},
    {1'b0, 4'b0010, 8'd3,  4'b0000, 8'd0, 8'd12, 4'd9},
    {1'b0, 4'b0001, 8'd2,  4'b0001, 8'd6, 8'd12, 4'd9},
    {1'b0, 4'b0000, 8'd0,  4'b0000, 8'd0, 8'd12, 4'd9},
    {1'b1, 4'b0000, 8'd0,  4'b0000, 8'd0, 8'd12, 4'd5}
  };

  int nchecks = 0, nerrs = 0;
  logic exp_v = 0, exp_l = 0, cur_v, cur_l, car_v = 0, car_l = 0;
  logic [CHW-1:0] exp_c = 0, cur_c, car_c = 0;
  logic [TSW-1:0] exp_t = 0, cur_t, car_t = 0;
  logic [NCH-1:0] ref_gate = '0;
  string exp_tag = "R1";

  function automatic string tag_name(input int t);
    case (t)
      2: return "R2";  3: return "R3";  5: return "R5";  6: return "R6";
      7: return "R7";  8: return "R8";  9: return "R9";  10: return "R10";
      default: return "R1";
    endcase
  endfunction

  function automatic int lowest(input logic [NCH-1:0] m);
    for (int i = NCH - 1; i >= 0; i--) if (m[i]) lowest = i;
  endfunction

  task automatic check(input string tag, input logic v, input logic [CHW-1:0] c,
                       input logic l, input logic [TSW-1:0] t);
    nchecks++;
    if (ev_valid !== v || ev_chan !== c || ev_level !== l || ev_stamp !== t) begin
      nerrs++;
      $display("FAIL %s: got v=%0d ch=%0d lvl=%0d ts=%0d, expected v=%0d ch=%0d lvl=%0d ts=%0d",
               tag, ev_valid, ev_chan, ev_level, ev_stamp, v, c, l, t);
    end
  endtask

  task automatic note_edge(input logic [NCH-1:0] m, input int d, input int len);
    int b = lowest(m);
    if (d < len) begin
      if (!cur_v) begin
        cur_v = 1; cur_c = CHW'(b); cur_l = gate_in[b];
        cur_t = TSW'((d > SUB - 1) ? SUB - 1 : d);
      end
    end else if (d == len && !car_v) begin
      car_v = 1; car_c = CHW'(b); car_l = gate_in[b]; car_t = '0;
    end
  endtask

  task automatic run_step(input logic en, input logic [NCH-1:0] m1, input int j1,
                          input logic [NCH-1:0] m2, input int j2, input int len,
                          input string tag);
    cur_v = car_v; cur_c = car_c; cur_l = car_l; cur_t = car_t;
    car_v = 0; car_c = '0; car_l = 0; car_t = '0;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (c == 1) check(exp_tag, exp_v, exp_c, exp_l, exp_t);
      if (c == len - 1) check("R4", exp_v, exp_c, exp_l, exp_t);
      step_strobe = (c == 0);
      if (c == 0) oversample_en = en;
      if (m1 != 0 && c == j1) begin gate_in ^= m1; if (en) note_edge(m1, j1 + 2, len); end
      if (m2 != 0 && c == j2) begin gate_in ^= m2; if (en) note_edge(m2, j2 + 2, len); end
    end
    if (!en && (gate_in ^ ref_gate) != 0 && !car_v) begin
      int b = lowest(gate_in ^ ref_gate);
      car_v = 1; car_c = CHW'(b); car_l = gate_in[b]; car_t = '0;
    end
    ref_gate = gate_in;
    if (cur_v) begin
      exp_v = 1; exp_c = cur_c; exp_l = cur_l; exp_t = cur_t;
    end else begin
      exp_v = 0; exp_c = '0; exp_l = 0; exp_t = '0;
    end
    exp_tag = tag;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        nerrs++; nchecks++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0, '0, 0, '0);
    rst_n = 1'b1;
    for (int i = 0; i < VN; i++) begin
      logic [36:0] v = VECS[i];
      run_step(v[36], v[35:32], int'(v[31:24]), v[23:20], int'(v[19:12]),
               int'(v[11:4]), tag_name(int'(v[3:0])));
    end
    run_step(1'b1, 4'b0001, 2, 4'b0000, 0, 12, "R2");
    run_step(1'b1, 4'b0000, 0, 4'b0000, 0, 12, "R5");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 0, '0, 0, '0);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end
endmodule